// File: doc/BRIEF.md
# Level Interrupt Combiner with Halfword Register Window

This block gathers thirty-two level-sensitive interrupt request lines from board peripherals and folds them into one active-low interrupt for the processor. Each request line first crosses into the block clock domain through a two-flop synchronizer. Its synchronized level is then visible to software through a pair of 16-bit status registers. A pair of 16-bit mask registers gates each line individually. The combined output is pulled low for as long as at least one unmasked line is high.

Software reaches the block through a simple single-cycle halfword bus slave. Writes are taken on the clock edge while `bus_sel` and `bus_wr` are both high. Read data is combinational and valid in the same cycle as the read strobe. The window also holds two device reset control registers, and every bit of these drives a reset output to one peripheral.

A request is cleared only at the peripheral that raised it: a status bit simply follows its input. The source count, register width, synchronizer depth, reset register count and all offsets are parameters. The default build has two status halves, two mask halves and two reset control registers.

Top module: `irq_combiner_regs`

## Requirements
- R1: After reset both mask registers read 0xFFFF, both reset control registers read 0x0000, every `dev_rst_o` bit is low and `irq_out_n` is high.
- R2: Source n is masked by bit (n mod 16) of the mask register at offset 0x030 for n below 16, or at offset 0x032 for n from 16 to 31. A 1 disables the source and a 0 enables it. Both mask registers are read/write.
- R3: Reading offset 0x020 returns the levels of sources 0 to 15, and reading 0x022 returns sources 16 to 31, with source n in bit (n mod 16). A status bit reflects its input within three clock edges of a change.
- R4: `irq_out_n` is driven low one clock after any source is pending (status bit 1 and mask bit 0). It is driven high one clock after no source is pending.
- R5: The status registers are read-only. A write to 0x020 or 0x022 changes no register and no output.
- R6: Status is level-type with no latching. When a source input falls, its status bit returns to 0 and `irq_out_n` returns high if nothing else is pending.
- R7: The reset control registers at 0x0D0 and 0x0D2 are read/write. Bit k of the register at 0x0D0 drives `dev_rst_o[k]`, and bit k of 0x0D2 drives `dev_rst_o[16+k]`. A 1 holds that reset asserted high. Bit 2 of 0x0D0 is the Ethernet controller reset.
- R8: A read of an unmapped or odd offset returns 0x0000. A write to such an offset has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is strobed |
| src_lvl | input | 32 | Level interrupt request inputs, active high |
| irq_out_n | output | 1 | Combined interrupt, active low, level |
| dev_rst_o | output | 32 | Peripheral reset outputs, active high |

## Verification
The assertions take for granted that an access lasts exactly one strobed cycle, with address and data stable around the edge. They also assume that every request input holds each level for at least two clock cycles, so the synchronizer pipeline reproduces it exactly. The bench drives all bus signals on the falling edge, one access at a time, and changes `src_lvl` only between accesses. After each change it waits four edges before it samples. Under these conditions the two-edge status delay and the one-edge combine delay can be checked exactly, and no sample ever lands on a metastable transition.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Kind of register hit by a decoded bus offset
   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_STAT = 2'd1,
      RK_MASK = 2'd2,
      RK_RST  = 2'd3
   } reg_kind_e;

   localparam int IDX_W = 4;

   typedef struct packed {
      reg_kind_e        kind;
      logic [IDX_W-1:0] idx;
   } reg_sel_t;

endpackage

// File: rtl/irqc_sync.sv
// Multi-stage level synchronizer; STAGES = 0 selects a plain pass-through.
module irqc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("irqc_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] sr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '0;
         end else begin
            sr[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
               sr[s] <= sr[s-1];
            end
         end
      end

      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/irqc_decode.sv
// Maps a byte offset onto a register kind and index within the window.
module irqc_decode
   import irqc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 2,
   parameter int NUM_RST   = 2,
   parameter int STAT_BASE = 'h020,
   parameter int MASK_BASE = 'h030,
   parameter int RST_BASE  = 'h0D0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   always_comb begin
      sel.kind = RK_NONE;
      sel.idx  = '0;
      if (!addr[0]) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(STAT_BASE + 2*b)) begin
               sel.kind = RK_STAT;
               sel.idx  = IDX_W'(b);
            end
            if (addr == ADDR_W'(MASK_BASE + 2*b)) begin
               sel.kind = RK_MASK;
               sel.idx  = IDX_W'(b);
            end
         end
         for (int r = 0; r < NUM_RST; r++) begin
            if (addr == ADDR_W'(RST_BASE + 2*r)) begin
               sel.kind = RK_RST;
               sel.idx  = IDX_W'(r);
            end
         end
      end
   end

endmodule

// File: rtl/irqc_bank.sv
// One halfword slice: mask storage (set-to-disable) and pending computation.
module irqc_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] pend_o
);

   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (mask_we) begin
         mask_q <= wdata;
      end
   end

   assign mask_o = mask_q;
   assign pend_o = stat_i & ~mask_q;

endmodule

// File: rtl/irqc_rstctl.sv
// Bank of read/write halfword registers driving peripheral reset outputs.
module irqc_rstctl #(
   parameter int W       = 16,
   parameter int NUM     = 2,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM-1:0]   we,
   input  logic [W-1:0]     wdata,
   output logic [NUM*W-1:0] regs_o
);

   for (genvar r = 0; r < NUM; r++) begin : g_reg
      logic [W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= W'(RST_VAL);
         end else if (we[r]) begin
            q <= wdata;
         end
      end

      assign regs_o[r*W +: W] = q;
   end

endmodule

// File: rtl/irq_combiner_regs.sv
module irq_combiner_regs
   import irqc_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int HALF_W      = 16,
   parameter int NUM_SRC     = 32,
   parameter int NUM_RST     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STAT_BASE   = 'h020,
   parameter int MASK_BASE   = 'h030,
   parameter int RST_BASE    = 'h0D0,
   parameter int RST_INIT    = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [HALF_W-1:0]       bus_wdata,
   output logic [HALF_W-1:0]       bus_rdata,
   input  logic [NUM_SRC-1:0]      src_lvl,
   output logic                    irq_out_n,
   output logic [NUM_RST*HALF_W-1:0] dev_rst_o
);

   localparam int NUM_BANKS = NUM_SRC / HALF_W;

   if (NUM_SRC % HALF_W != 0) begin : g_chk_split
      $error("irq_combiner_regs: NUM_SRC must be a multiple of HALF_W");
   end
   if (NUM_BANKS > (1 << IDX_W) || NUM_RST > (1 << IDX_W)) begin : g_chk_idx
      $error("irq_combiner_regs: too many registers for the index field");
   end
   if (NUM_RST < 1) begin : g_chk_rst
      $error("irq_combiner_regs: NUM_RST must be at least 1");
   end

   // Synchronized levels; the last synchronizer stage is the status register
   logic [NUM_SRC-1:0] stat_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] pend_w;

   irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_lvl),
      .q     (stat_q)
   );

   reg_sel_t dsel;

   irqc_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .NUM_RST   (NUM_RST),
      .STAT_BASE (STAT_BASE),
      .MASK_BASE (MASK_BASE),
      .RST_BASE  (RST_BASE)
   ) u_dec (
      .addr (bus_addr),
      .sel  (dsel)
   );

   logic wr_acc;
   logic rd_acc;
   assign wr_acc = bus_sel & bus_wr;
   assign rd_acc = bus_sel & ~bus_wr;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic we_b;
      assign we_b = wr_acc && (dsel.kind == RK_MASK) && (dsel.idx == IDX_W'(b));

      irqc_bank #(.W(HALF_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .stat_i  (stat_q[b*HALF_W +: HALF_W]),
         .mask_we (we_b),
         .wdata   (bus_wdata),
         .mask_o  (mask_q[b*HALF_W +: HALF_W]),
         .pend_o  (pend_w[b*HALF_W +: HALF_W])
      );
   end

   logic [NUM_RST-1:0] rst_we;
   for (genvar r = 0; r < NUM_RST; r++) begin : g_rst_we
      assign rst_we[r] = wr_acc && (dsel.kind == RK_RST) && (dsel.idx == IDX_W'(r));
   end

   irqc_rstctl #(.W(HALF_W), .NUM(NUM_RST), .RST_VAL(RST_INIT)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rst_we),
      .wdata  (bus_wdata),
      .regs_o (dev_rst_o)
   );

   // Combined level output, registered, active low
   logic irq_n_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n_q <= 1'b1;
      end else begin
         irq_n_q <= ~|pend_w;
      end
   end
   assign irq_out_n = irq_n_q;

   // Same-cycle read multiplexer
   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         case (dsel.kind)
            RK_STAT: bus_rdata = stat_q[int'(dsel.idx)*HALF_W +: HALF_W];
            RK_MASK: bus_rdata = mask_q[int'(dsel.idx)*HALF_W +: HALF_W];
            RK_RST:  bus_rdata = dev_rst_o[int'(dsel.idx)*HALF_W +: HALF_W];
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int ADDR_W      = 12,
   parameter int HALF_W      = 16,
   parameter int NUM_SRC     = 32,
   parameter int NUM_RST     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STAT_BASE   = 'h020,
   parameter int MASK_BASE   = 'h030,
   parameter int RST_BASE    = 'h0D0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_sel,
   input logic                      bus_wr,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [HALF_W-1:0]         bus_wdata,
   input logic [HALF_W-1:0]         bus_rdata,
   input logic [NUM_SRC-1:0]        src_lvl,
   input logic                      irq_out_n,
   input logic [NUM_RST*HALF_W-1:0] dev_rst_o,
   input logic [NUM_SRC-1:0]        stat_q,
   input logic [NUM_SRC-1:0]        mask_q
);

   localparam int NB = NUM_SRC / HALF_W;

   function automatic logic hits_map(input logic [ADDR_W-1:0] a);
      logic h;
      h = 1'b0;
      for (int i = 0; i < NB; i++) begin
         if (a == ADDR_W'(STAT_BASE + 2*i) || a == ADDR_W'(MASK_BASE + 2*i)) h = 1'b1;
      end
      for (int i = 0; i < NUM_RST; i++) begin
         if (a == ADDR_W'(RST_BASE + 2*i)) h = 1'b1;
      end
      return h;
   endfunction

   // R1: state right after reset release
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (mask_q == '1 && irq_out_n && dev_rst_o == '0));

   // R4: combined output follows pending with one cycle of delay
   a_r4_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & ~mask_q)) |=> !irq_out_n);
   a_r4_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat_q & ~mask_q)) |=> irq_out_n);

   // R5: status write leaves masks and resets alone
   a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(STAT_BASE))
      |=> (mask_q == $past(mask_q) && dev_rst_o == $past(dev_rst_o)));

   // R8: unmapped reads return zero, unmapped writes change nothing
   a_r8_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !hits_map(bus_addr)) |-> bus_rdata == '0);
   a_r8_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !hits_map(bus_addr))
      |=> (mask_q == $past(mask_q) && dev_rst_o == $past(dev_rst_o)));

   // R2: mask halves load written data
   for (genvar b = 0; b < NB; b++) begin : g_mask_chk
      a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == ADDR_W'(MASK_BASE + 2*b))
         |=> mask_q[b*HALF_W +: HALF_W] == $past(bus_wdata));
   end

   // R7: reset outputs take written data
   for (genvar r = 0; r < NUM_RST; r++) begin : g_rst_chk
      a_r7_rst_write: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == ADDR_W'(RST_BASE + 2*r))
         |=> dev_rst_o[r*HALF_W +: HALF_W] == $past(bus_wdata));
   end

   // R3 / R6: status equals the input two edges earlier (default depth only)
   if (SYNC_STAGES == 2) begin : g_sync_chk
      a_r3_status_delay: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n, 1) && $past(rst_n, 2)) |-> stat_q == $past(src_lvl, 2));
   end

endmodule

bind irq_combiner_regs irqc_chk #(
   .ADDR_W      (ADDR_W),
   .HALF_W      (HALF_W),
   .NUM_SRC     (NUM_SRC),
   .NUM_RST     (NUM_RST),
   .SYNC_STAGES (SYNC_STAGES),
   .STAT_BASE   (STAT_BASE),
   .MASK_BASE   (MASK_BASE),
   .RST_BASE    (RST_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .src_lvl   (src_lvl),
   .irq_out_n (irq_out_n),
   .dev_rst_o (dev_rst_o),
   .stat_q    (stat_q),
   .mask_q    (mask_q)
);

// File: tb/tb_irq_combiner_regs.sv
`timescale 1ns/1ps
module tb_irq_combiner_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [31:0] src_lvl = '0;
   logic        irq_out_n;
   logic [31:0] dev_rst_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_combiner_regs dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_lvl   (src_lvl),
      .irq_out_n (irq_out_n),
      .dev_rst_o (dev_rst_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [15:0] exp, input string req);
      logic [15:0] v;
      rd(a, v);
      check(v === exp, req, 32'(v), 32'(exp));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] x;
      logic [31:0] p;
      logic [31:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(irq_out_n === 1'b1, "R1 irq high", 32'(irq_out_n), 1);
      check(dev_rst_o === 32'h0, "R1 resets low", dev_rst_o, 0);
      rd_chk(12'h030, 16'hFFFF, "R1 mask lo");
      rd_chk(12'h032, 16'hFFFF, "R1 mask hi");
      rd_chk(12'h0D0, 16'h0000, "R1 rstctl 0");
      rd_chk(12'h0D2, 16'h0000, "R1 rstctl 1");

      // Everything masked: a raised source must not pull the output low (R2)
      src_lvl = 32'h8001_0001;
      settle();
      check(irq_out_n === 1'b1, "R2 all masked", 32'(irq_out_n), 1);
      src_lvl = '0;

      // Per-source sweep: R2, R3, R4, R6
      wr(12'h030, 16'h0000);
      wr(12'h032, 16'h0000);
      for (int i = 0; i < 32; i++) begin
         logic [31:0] one;
         logic [11:0] ma;
         one = 32'h1 << i;
         ma = (i < 16) ? 12'h030 : 12'h032;
         src_lvl = one;
         settle();
         rd_chk(12'h020, one[15:0], "R3 status lo");
         rd_chk(12'h022, one[31:16], "R3 status hi");
         check(irq_out_n === 1'b0, "R4 pending low", 32'(irq_out_n), 0);
         wr(ma, 16'(1 << (i % 16)));
         settle();
         check(irq_out_n === 1'b1, "R2 bit masks source", 32'(irq_out_n), 1);
         rd_chk(ma, 16'(1 << (i % 16)), "R2 mask readback");
         wr(ma, 16'h0000);
         settle();
         check(irq_out_n === 1'b0, "R2 unmask re-asserts", 32'(irq_out_n), 0);
         src_lvl = '0;
         settle();
         rd_chk((i < 16) ? 12'h020 : 12'h022, 16'h0000, "R6 status clears");
         check(irq_out_n === 1'b1, "R6 irq released", 32'(irq_out_n), 1);
      end

      // Mixed patterns, expected output computed arithmetically (R4)
      x = 32'h1234_5678;
      for (int k = 0; k < 40; k++) begin
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         p = x;
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         m = (k % 4 == 0) ? p : ((k % 4 == 1) ? ~p : (x | x << 3));
         src_lvl = p;
         wr(12'h030, m[15:0]);
         wr(12'h032, m[31:16]);
         settle();
         check(irq_out_n === ((p & ~m) == 0), "R4 pattern", 32'(irq_out_n),
               32'((p & ~m) == 0));
      end

      // R5: status is read-only
      src_lvl = 32'h00F0_0A0A;
      wr(12'h030, 16'h1234);
      settle();
      wr(12'h020, 16'hFFFF);
      wr(12'h022, 16'h0000);
      rd_chk(12'h020, 16'h0A0A, "R5 status lo unchanged");
      rd_chk(12'h022, 16'h00F0, "R5 status hi unchanged");
      rd_chk(12'h030, 16'h1234, "R5 mask untouched");
      check(dev_rst_o === 32'h0, "R5 resets untouched", dev_rst_o, 0);

      // R7: reset control
      wr(12'h0D0, 16'h0004);
      @(negedge clk);
      check(dev_rst_o === 32'h0000_0004, "R7 ethernet reset", dev_rst_o, 32'h4);
      wr(12'h0D2, 16'hA5C3);
      rd_chk(12'h0D2, 16'hA5C3, "R7 rstctl 1 readback");
      check(dev_rst_o === 32'hA5C3_0004, "R7 outputs", dev_rst_o, 32'hA5C3_0004);
      wr(12'h0D0, 16'h0000);
      rd_chk(12'h0D0, 16'h0000, "R7 release");
      check(dev_rst_o[2] === 1'b0, "R7 ethernet released", 32'(dev_rst_o[2]), 0);

      // R8: unmapped and odd offsets
      rd_chk(12'h000, 16'h0000, "R8 read 0x000");
      rd_chk(12'h024, 16'h0000, "R8 read 0x024");
      rd_chk(12'h031, 16'h0000, "R8 read odd 0x031");
      rd_chk(12'h0D4, 16'h0000, "R8 read 0x0D4");
      rd_chk(12'hFFE, 16'h0000, "R8 read 0xFFE");
      wr(12'h031, 16'hFFFF);
      wr(12'h0D1, 16'hFFFF);
      wr(12'h034, 16'hFFFF);
      wr(12'h0D4, 16'hFFFF);
      rd_chk(12'h030, 16'h1234, "R8 mask lo kept");
      rd_chk(12'h032, m[31:16], "R8 mask hi kept");
      check(dev_rst_o === 32'hA5C3_0000, "R8 resets kept", dev_rst_o, 32'hA5C3_0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule